// File: doc/BRIEF.md
# DMA Request Router with Interval-Gated Channels

This block sits between a set of peripheral DMA request lines and the request inputs of a DMA engine. Each DMA channel has an 8-bit configuration word. The word chooses one of 64 peripheral request lines (slot numbers), turns the channel on or off, and, on the lowest channels only, selects an interval-gated mode. Software writes and reads these words over a simple single-cycle register bus.

In plain routing mode a channel forwards its chosen peripheral request. The path has one register stage, so a change of configuration cannot produce a glitch on the output. On the interval-capable channels, gated mode holds the routed request back until an external interval timer pulses that channel's trigger line. One request is then let through. It stays asserted until the DMA engine acknowledges it. In this way a peripheral can be served at a fixed rate without the processor taking part.

Top module: `dma_req_router`

## Requirements
- R1: Configuration word layout: bit 7 is channel-on, bit 6 is gated-mode, and bits 5..0 are the slot number. A write (regWrEn high, regAddr = channel index) updates the word at that clock edge. regRdData combinationally returns the word of the channel at regAddr, and returns 0 for addresses with no channel.
- R2: After reset every configuration word reads 0 and every chanReq bit is 0.
- R3: A channel whose bit 7 is 0 drives chanReq low from the next edge on, and it loses any pending trigger.
- R4: A channel that is on and in plain mode drives chanReq, one clock after sampling, equal to srcReq[slot].
- R5: Slot number 0 selects no source. Such a channel keeps chanReq low whatever srcReq holds.
- R6: Only channels 0..3 are interval-capable. On channels 4 and above, bit 6 ignores writes and reads as 0, so those channels always route plainly.
- R7: In gated mode a 0-to-1 change of trigIn[c] (sampled at clock edges) arms channel c. While armed, chanReq[c] follows srcReq[slot] with one clock of delay. A trigger input held high does not re-arm the channel.
- R8: In gated mode, chanAck[c] sampled high while chanReq[c] is high drives chanReq[c] low at that edge and disarms the channel. In plain mode chanAck has no effect.
- R9: A configuration write does not change chanReq at the edge that performs it. The new word first governs the value chanReq takes at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W (3) | Channel index for read and write |
| regWrData | input | 8 | Configuration word to write |
| regRdData | output | 8 | Configuration word of the addressed channel |
| srcReq | input | 64 | Peripheral request lines, indexed by slot |
| trigIn | input | NUM_TRIG (4) | Interval timer pulses for channels 0..3 |
| chanAck | input | NUM_CHAN (8) | Per-channel acknowledge from the DMA engine |
| chanReq | output | NUM_CHAN (8) | Per-channel request to the DMA engine |

## Verification
On every cycle the assertions check four things: a channel that is off or has slot 0 stays quiet, a channel in plain mode copies its chosen source one clock later, an acknowledged gated request drops at once, and the gated-mode bit never reads back as set on a routing-only channel. Other behaviour needs a history of events and only the bench scenarios can show it. This covers arming by a trigger edge rather than a level, holding a request across several cycles until acknowledge, re-arming after the trigger falls and rises again, and a slot change on a live channel taking effect one edge late. A reference model in the bench follows all of these under random traffic.

// File: rtl/dmaroute_pkg.sv
package dmaroute_pkg;
  localparam int SLOT_W   = 6;
  localparam int NUM_SRC  = 1 << SLOT_W;
  localparam int CFG_W    = 8;
  localparam int ON_BIT   = 7;
  localparam int GATE_BIT = 6;

  // per-channel strobes from control to datapath
  typedef struct packed {
    logic              on;
    logic              gated;
    logic              trigRise;
    logic [SLOT_W-1:0] slot;
  } chanStrobe_t;
endpackage

// File: rtl/dma_req_router_ctrl.sv
module dma_req_router_ctrl
  import dmaroute_pkg::*;
#(
  parameter int NUM_CHAN = 8,
  parameter int NUM_TRIG = 4,
  parameter int ADDR_W   = $clog2(NUM_CHAN)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              regWrEn,
  input  logic [ADDR_W-1:0]                 regAddr,
  input  logic [CFG_W-1:0]                  regWrData,
  output logic [CFG_W-1:0]                  regRdData,
  input  logic [NUM_TRIG-1:0]               trigIn,
  output chanStrobe_t [NUM_CHAN-1:0]        strb
);
  logic [NUM_CHAN-1:0]             onQ;
  logic [NUM_CHAN-1:0][SLOT_W-1:0] slotQ;
  logic [NUM_CHAN-1:0]             gatedW;
  logic [NUM_CHAN-1:0]             riseW;
  logic [NUM_TRIG-1:0]             trigPrevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) trigPrevQ <= '0;
    else       trigPrevQ <= trigIn;
  end

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    logic wrHit;
    assign wrHit = regWrEn && (regAddr == ADDR_W'(c));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        onQ[c]   <= 1'b0;
        slotQ[c] <= '0;
      end else if (wrHit) begin
        onQ[c]   <= regWrData[ON_BIT];
        slotQ[c] <= regWrData[SLOT_W-1:0];
      end
    end

    if (c < NUM_TRIG) begin : g_gate
      logic gateQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)      gateQ <= 1'b0;
        else if (wrHit) gateQ <= regWrData[GATE_BIT];
      end
      assign gatedW[c] = gateQ;
      assign riseW[c]  = trigIn[c] & ~trigPrevQ[c];
    end else begin : g_plain
      assign gatedW[c] = 1'b0;
      assign riseW[c]  = 1'b0;
    end

    assign strb[c].on       = onQ[c];
    assign strb[c].gated    = gatedW[c];
    assign strb[c].trigRise = riseW[c];
    assign strb[c].slot     = slotQ[c];
  end

  always_comb begin
    regRdData = '0;
    for (int c = 0; c < NUM_CHAN; c++) begin
      if (regAddr == ADDR_W'(c)) regRdData = {onQ[c], gatedW[c], slotQ[c]};
    end
  end
endmodule

// File: rtl/dma_req_router_dp.sv
module dma_req_router_dp
  import dmaroute_pkg::*;
#(
  parameter int NUM_CHAN = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  chanStrobe_t [NUM_CHAN-1:0] strb,
  input  logic [NUM_SRC-1:0]         srcReq,
  input  logic [NUM_CHAN-1:0]        chanAck,
  output logic [NUM_CHAN-1:0]        chanReq
);
  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    logic srcSel, armedQ, reqQ;
    assign srcSel = (strb[c].slot != '0) && srcReq[strb[c].slot];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        armedQ <= 1'b0;
        reqQ   <= 1'b0;
      end else if (!strb[c].on || !strb[c].gated) begin
        armedQ <= 1'b0;
        reqQ   <= strb[c].on & srcSel;
      end else begin
        armedQ <= strb[c].trigRise | (armedQ & ~(chanAck[c] & reqQ));
        reqQ   <= armedQ & ~chanAck[c] & srcSel;
      end
    end
    assign chanReq[c] = reqQ;
  end
endmodule

// File: rtl/dma_req_router.sv
module dma_req_router
  import dmaroute_pkg::*;
#(
  parameter int NUM_CHAN = 8,
  parameter int NUM_TRIG = 4,
  parameter int ADDR_W   = $clog2(NUM_CHAN)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [CFG_W-1:0]    regWrData,
  output logic [CFG_W-1:0]    regRdData,
  input  logic [NUM_SRC-1:0]  srcReq,
  input  logic [NUM_TRIG-1:0] trigIn,
  input  logic [NUM_CHAN-1:0] chanAck,
  output logic [NUM_CHAN-1:0] chanReq
);
  chanStrobe_t [NUM_CHAN-1:0] strb;

  dma_req_router_ctrl #(.NUM_CHAN(NUM_CHAN), .NUM_TRIG(NUM_TRIG), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .trigIn(trigIn), .strb(strb)
  );

  dma_req_router_dp #(.NUM_CHAN(NUM_CHAN)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .srcReq(srcReq),
    .chanAck(chanAck), .chanReq(chanReq)
  );
endmodule

// File: rtl/dma_req_router_chk.sv
module dma_req_router_chk
  import dmaroute_pkg::*;
#(
  parameter int NUM_CHAN = 8,
  parameter int NUM_TRIG = 4,
  parameter int ADDR_W   = $clog2(NUM_CHAN)
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [ADDR_W-1:0]          regAddr,
  input logic [CFG_W-1:0]           regRdData,
  input logic [NUM_SRC-1:0]         srcReq,
  input logic [NUM_CHAN-1:0]        chanAck,
  input logic [NUM_CHAN-1:0]        chanReq,
  input chanStrobe_t [NUM_CHAN-1:0] strb
);
  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chk
    // R3
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
      !strb[c].on |=> !chanReq[c]);
    // R5
    no_src_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb[c].slot == '0) |=> !chanReq[c]);
    // R4
    plain_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb[c].on && !strb[c].gated && strb[c].slot != '0)
        |=> (chanReq[c] == $past(srcReq[strb[c].slot])));
    // R8
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb[c].on && strb[c].gated && chanReq[c] && chanAck[c]) |=> !chanReq[c]);
  end

  // R6
  plain_chan_gate_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (int'(regAddr) >= NUM_TRIG) |-> !regRdData[GATE_BIT]);
endmodule

bind dma_req_router dma_req_router_chk #(
  .NUM_CHAN(NUM_CHAN), .NUM_TRIG(NUM_TRIG), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regRdData(regRdData),
  .srcReq(srcReq), .chanAck(chanAck), .chanReq(chanReq), .strb(strb)
);

// File: tb/tb_dma_req_router.sv
module tb_dma_req_router;
  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [2:0]  regAddr;
  logic [7:0]  regWrData;
  logic [7:0]  regRdData;
  logic [63:0] srcReq;
  logic [3:0]  trigIn;
  logic [7:0]  chanAck;
  logic [7:0]  chanReq;

  int total = 0;
  int bad   = 0;

  logic [7:0] mCfg [8];
  logic [3:0] mPrev;
  logic [7:0] mArmed;
  logic [7:0] mReq;

  always #10 clk = ~clk;

  dma_req_router dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .srcReq(srcReq),
    .trigIn(trigIn), .chanAck(chanAck), .chanReq(chanReq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // advance one clock; model computes the next outputs from present inputs
  task automatic tick();
    logic [7:0] nReq, nArm;
    for (int c = 0; c < 8; c++) begin
      logic en, gt, sb, rise;
      logic [5:0] sl;
      en = mCfg[c][7]; gt = mCfg[c][6]; sl = mCfg[c][5:0];
      sb = (sl != 0) && srcReq[sl];
      rise = (c < 4) ? (trigIn[c] & ~mPrev[c]) : 1'b0;
      if (!en || !gt) begin
        nArm[c] = 1'b0;
        nReq[c] = en & sb;
      end else begin
        nArm[c] = rise | (mArmed[c] & ~(chanAck[c] & mReq[c]));
        nReq[c] = mArmed[c] & ~chanAck[c] & sb;
      end
    end
    if (regWrEn) mCfg[regAddr] = (regAddr >= 4) ? (regWrData & 8'hBF) : regWrData;
    mPrev = trigIn; mArmed = nArm; mReq = nReq;
    @(posedge clk);
    @(negedge clk);
    check("R4/R7 model", {24'd0, chanReq}, {24'd0, mReq});
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [7:0] exp);
    regAddr = a;
    #1;
    check(req, {24'd0, regRdData}, {24'd0, exp});
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; regWrEn = 1'b0; regAddr = '0; regWrData = '0;
    srcReq = '0; trigIn = '0; chanAck = '0;
    for (int c = 0; c < 8; c++) mCfg[c] = '0;
    mPrev = '0; mArmed = '0; mReq = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R2 reset state
    check("R2 chanReq", {24'd0, chanReq}, 32'd0);
    for (int c = 0; c < 8; c++) rd("R2 cfg", 3'(c), 8'h00);

    // R1 / R6 register layout and readback
    wr(3'd5, 8'hFF);
    rd("R6 gate bit on ch5", 3'd5, 8'hBF);
    wr(3'd1, 8'h8A);
    rd("R1 readback ch1", 3'd1, 8'h8A);

    // R4 plain routing
    srcReq[10] = 1'b1; tick();
    check("R4 pass high", {31'd0, chanReq[1]}, 32'd1);
    srcReq = '0; tick();
    check("R4 pass low", {31'd0, chanReq[1]}, 32'd0);

    // R3 disabled channel
    wr(3'd1, 8'h0A);
    srcReq = '1; tick(); tick();
    check("R3 off quiet", {31'd0, chanReq[1]}, 32'd0);

    // R5 slot zero
    wr(3'd2, 8'h80); tick();
    check("R5 slot0 quiet", {31'd0, chanReq[2]}, 32'd0);

    // R9 slot change on a live channel
    srcReq = 64'd1 << 5;
    wr(3'd3, 8'h85); tick();
    check("R9 before", {31'd0, chanReq[3]}, 32'd1);
    wr(3'd3, 8'h86);
    check("R9 write edge keeps old", {31'd0, chanReq[3]}, 32'd1);
    tick();
    check("R9 new slot", {31'd0, chanReq[3]}, 32'd0);

    // R7 / R8 gated channel 0 on slot 3
    srcReq = '0;
    wr(3'd0, 8'hC3);
    srcReq[3] = 1'b1;
    repeat (3) tick();
    check("R7 no trigger holds", {31'd0, chanReq[0]}, 32'd0);
    trigIn[0] = 1'b1; tick();
    check("R7 arm edge", {31'd0, chanReq[0]}, 32'd0);
    tick();
    check("R7 forwarded", {31'd0, chanReq[0]}, 32'd1);
    tick();
    check("R8 held until ack", {31'd0, chanReq[0]}, 32'd1);
    chanAck[0] = 1'b1; tick();
    check("R8 ack drops", {31'd0, chanReq[0]}, 32'd0);
    chanAck[0] = 1'b0; tick(); tick();
    check("R7 level no rearm", {31'd0, chanReq[0]}, 32'd0);
    trigIn[0] = 1'b0; tick();
    trigIn[0] = 1'b1; tick(); tick();
    check("R7 rearm", {31'd0, chanReq[0]}, 32'd1);
    chanAck[0] = 1'b1; tick(); chanAck[0] = 1'b0; trigIn[0] = 1'b0;

    // R8 ack ignored in plain mode
    wr(3'd1, 8'h8A);
    srcReq[10] = 1'b1; chanAck[1] = 1'b1; tick(); tick();
    check("R8 plain ack ignored", {31'd0, chanReq[1]}, 32'd1);
    chanAck[1] = 1'b0;

    // R6 gate bit dropped on ch4: routes without trigger
    wr(3'd4, 8'hC3); tick();
    check("R6 ch4 plain", {31'd0, chanReq[4]}, 32'd1);
    rd("R6 ch4 readback", 3'd4, 8'h83);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 9) == 0) begin
        logic [7:0] d;
        d = {$urandom_range(0, 3) != 0 ? 1'b1 : 1'b0, 1'($urandom), 6'($urandom_range(0, 7))};
        wr(3'($urandom_range(0, 7)), d);
      end
      srcReq = {$urandom, $urandom} & {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) trigIn = 4'($urandom);
      chanAck = 8'($urandom) & mReq;
      tick();
      if ($urandom_range(0, 7) == 0) begin
        logic [2:0] a;
        a = 3'($urandom);
        rd("R1 random readback", a, mCfg[a]);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule